// File: doc/BRIEF.md
# Priority Loadable Program Counter

This block is a word-wide counting register of the sort that supplies the instruction address in a small processor. At each rising clock edge it can clear itself, take a parallel word from its data input, advance by one, or keep what it has. Three synchronous control inputs choose between these actions. When more than one is raised, clear beats load and load beats increment.

The register is written only when at least one control is high. With all controls low the stored word is left alone. The next value is built by an incrementer, then a load-select stage, then a clear-select stage. The output comes straight from the register, so any request shows up on the output one edge after it is presented. The register starts at zero in simulation. Counting past the all-ones word rolls over to zero, and no carry or flag is produced.

Top module: `prog_counter`

## Requirements
- R1: Before the first clock edge the count output reads zero.
- R2: With clr_i high at a rising edge, the count becomes zero after that edge, whatever ld_i, step_i and din_i are.
- R3: With clr_i low and ld_i high at a rising edge, the count becomes din_i after that edge, whatever step_i is.
- R4: With clr_i and ld_i low and step_i high at a rising edge, the count becomes its previous value plus one after that edge.
- R5: With clr_i, ld_i and step_i all low at a rising edge, the count keeps its value, whatever din_i is.
- R6: Advancing from the all-ones word (16'hFFFF at the default width) gives zero, with no other output.
- R7: The output changes only at rising clock edges. Changing the inputs between edges leaves count_o unchanged until the next edge.
- R8: From zero, three advances give 1, 2, 3. A clear then gives 0. Loading 17 and advancing five times gives 22, and the count stays at 22 while all controls are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all inputs are sampled on its rising edge |
| clr_i | input | 1 | Synchronous clear to zero, highest priority |
| ld_i | input | 1 | Synchronous parallel load of din_i |
| step_i | input | 1 | Synchronous advance by one, lowest priority |
| din_i | input | WIDTH (16) | Word to load |
| count_o | output | WIDTH (16) | Registered count |

## Verification
The bench first runs the fixed script of advances, clears, a load of 17 and idle cycles. This shows that each single control works on its own and that the output lags by one edge. It then raises every combination of two and three controls together, each with a data word that differs from the count. Only the right priority gives the expected word, so these cases separate clear from load from increment. A load of all-ones followed by an advance covers the rollover. Idle cycles with a changing din_i, and input changes made between edges, show that nothing leaks through when the register is not written. A long stretch of pseudo-random control and data patterns is then compared edge by edge against a behavioural model.

// File: rtl/prog_counter_pkg.sv
package prog_counter_pkg;

    // Action chosen for the coming edge, in order of increasing priority.
    typedef enum logic [1:0] {
        ACT_KEEP  = 2'd0,
        ACT_STEP  = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } pc_act_e;

    typedef struct packed {
        logic clr;
        logic ld;
        logic step;
    } pc_ctrl_t;

    // Fixed priority: clear over load over step.
    function automatic pc_act_e pick_action(input pc_ctrl_t c);
        if (c.clr)       return ACT_CLEAR;
        else if (c.ld)   return ACT_LOAD;
        else if (c.step) return ACT_STEP;
        else             return ACT_KEEP;
    endfunction

    function automatic logic any_request(input pc_ctrl_t c);
        return c.clr | c.ld | c.step;
    endfunction

endpackage

// File: rtl/pc_ctrl_decode.sv
module pc_ctrl_decode
    import prog_counter_pkg::*;
(
    input  pc_ctrl_t ctrl_i,
    output pc_act_e  act_o,
    output logic     wr_en_o
);

    always_comb begin
        act_o   = pick_action(ctrl_i);
        wr_en_o = any_request(ctrl_i);
    end

endmodule

// File: rtl/pc_next_path.sv
module pc_next_path #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] din_i,
    input  logic             ld_sel_i,
    input  logic             clr_sel_i,
    output logic [WIDTH-1:0] next_o
);

    localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
    localparam logic [WIDTH-1:0] ZERO = '0;

    logic [WIDTH-1:0] bumped;
    logic [WIDTH-1:0] after_ld;

    // Incrementer, then load mux, then clear mux; the carry out is dropped.
    always_comb begin
        bumped   = cur_i + ONE;
        after_ld = ld_sel_i  ? din_i : bumped;
        next_o   = clr_sel_i ? ZERO  : after_ld;
    end

endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] q_r = '0;

    always_ff @(posedge clk_i) begin
        if (wr_en_i) q_r <= d_i;
    end

    assign q_o = q_r;

endmodule

// File: rtl/prog_counter.sv
module prog_counter
    import prog_counter_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] count_o
);

    pc_ctrl_t         ctrl;
    pc_act_e          act;
    logic             wr_en;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] nxt;

    assign ctrl = '{clr: clr_i, ld: ld_i, step: step_i};

    pc_ctrl_decode u_dec (
        .ctrl_i  (ctrl),
        .act_o   (act),
        .wr_en_o (wr_en)
    );

    pc_next_path #(.WIDTH(WIDTH)) u_next (
        .cur_i     (cur),
        .din_i     (din_i),
        .ld_sel_i  (act == ACT_LOAD),
        .clr_sel_i (act == ACT_CLEAR),
        .next_o    (nxt)
    );

    pc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk_i   (clk_i),
        .wr_en_i (wr_en),
        .d_i     (nxt),
        .q_o     (cur)
    );

    assign count_o = cur;

endmodule

// File: rtl/prog_counter_chk.sv
module prog_counter_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk_i,
    input logic             clr_i,
    input logic             ld_i,
    input logic             step_i,
    input logic [WIDTH-1:0] din_i,
    input logic [WIDTH-1:0] count_o
);

    localparam logic [WIDTH-1:0] ONES = '1;

    // Low until the first edge, so no property looks before time zero.
    logic seen_q = 1'b0;
    always_ff @(posedge clk_i) seen_q <= 1'b1;

    initial begin
        a_r1_zero_start: assert (count_o == '0);
    end

    a_r2_clear_wins: assert property (@(posedge clk_i) disable iff (!seen_q)
        clr_i |=> count_o == '0);

    a_r3_load_over_step: assert property (@(posedge clk_i) disable iff (!seen_q)
        (!clr_i && ld_i) |=> count_o == $past(din_i));

    a_r4_step_adds_one: assert property (@(posedge clk_i) disable iff (!seen_q)
        (!clr_i && !ld_i && step_i) |=> count_o == $past(count_o) + 1'b1);

    a_r5_idle_holds: assert property (@(posedge clk_i) disable iff (!seen_q)
        (!clr_i && !ld_i && !step_i) |=> $stable(count_o));

    a_r6_rollover: assert property (@(posedge clk_i) disable iff (!seen_q)
        (!clr_i && !ld_i && step_i && count_o == ONES) |=> count_o == '0);

endmodule

bind prog_counter prog_counter_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i   (clk_i),
    .clr_i   (clr_i),
    .ld_i    (ld_i),
    .step_i  (step_i),
    .din_i   (din_i),
    .count_o (count_o)
);

// File: tb/prog_counter_tb.sv
module prog_counter_tb;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         clr = 1'b0;
    logic         ld = 1'b0;
    logic         stp = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] count;

    int n_tests = 0;
    int n_fail  = 0;
    int model   = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_counter #(.WIDTH(W)) u_dut (
        .clk_i   (clk),
        .clr_i   (clr),
        .ld_i    (ld),
        .step_i  (stp),
        .din_i   (din),
        .count_o (count)
    );

    task automatic check(input string tag, input int exp);
        n_tests++;
        if (int'(count) != exp) begin
            n_fail++;
            $display("FAIL %s: count=%0h expected=%0h at %0t", tag, count, exp, $time);
        end
    endtask

    // Drive at the falling edge, let one rising edge commit, update the model, compare at the next falling edge.
    task automatic cyc(input string tag, input bit c, input bit l, input bit s, input int d);
        clr = c; ld = l; stp = s; din = W'(d);
        @(posedge clk);
        if (c)      model = 0;
        else if (l) model = d & 16'hFFFF;
        else if (s) model = (model + 1) & 16'hFFFF;
        @(negedge clk);
        check(tag, model);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int lfsr;
        #2;
        check("R1", 0);
        @(negedge clk);

        // R8 scripted sequence
        cyc("R8 step", 0, 0, 1, 0);
        cyc("R8 step", 0, 0, 1, 0);
        cyc("R8 step", 0, 0, 1, 0);
        check("R8 three", 3);
        cyc("R8 clear", 1, 0, 0, 0);
        cyc("R8 clear", 1, 0, 0, 0);
        cyc("R8 load17", 0, 1, 0, 17);
        for (int i = 0; i < 5; i++) cyc("R8 count", 0, 0, 1, 17);
        check("R8 22", 22);
        cyc("R8 idle", 0, 0, 0, 0);
        cyc("R8 idle", 0, 0, 0, 0);
        check("R8 stays", 22);

        // R7: inputs change between edges, output must not move
        clr = 1'b1; ld = 1'b1; stp = 1'b1; din = 16'h5555;
        #1 check("R7 no comb path", 22);
        clr = 1'b0; ld = 1'b0; stp = 1'b0;
        @(negedge clk);
        check("R7 idle edge", 22);

        // R2 / R3 priority combinations
        cyc("R3 load", 0, 1, 0, 16'h0100);
        cyc("R2 clr+ld+step", 1, 1, 1, 16'hBEEF);
        cyc("R3 load", 0, 1, 0, 16'h0200);
        cyc("R2 clr+ld", 1, 1, 0, 16'h1234);
        cyc("R3 load", 0, 1, 0, 16'h0300);
        cyc("R2 clr+step", 1, 0, 1, 16'h1234);
        cyc("R3 ld+step", 0, 1, 1, 16'h1234);
        check("R3 load wins", 16'h1234);
        cyc("R4 step", 0, 0, 1, 16'h7777);
        check("R4 plus one", 16'h1235);

        // R5 idle with changing data
        cyc("R5 idle", 0, 0, 0, 16'hFFFF);
        cyc("R5 idle", 0, 0, 0, 16'h0000);
        check("R5 held", 16'h1235);

        // R6 rollover
        cyc("R6 load ones", 0, 1, 0, 16'hFFFF);
        cyc("R6 wrap", 0, 0, 1, 0);
        check("R6 zero", 0);
        cyc("R6 next", 0, 0, 1, 0);

        // Pseudo-random compare against the model
        lfsr = 32'h1ACE5;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h000B8000 : 0);
            cyc("R2-model", lfsr[0] & lfsr[5] & lfsr[9], lfsr[1] & lfsr[3],
                lfsr[2] | lfsr[7], lfsr[19:4]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule